// File: doc/BRIEF.md
# Debug Bus-Match Trigger Comparators

This block watches a CPU bus on behalf of a debug trigger unit. Two 16-bit reference comparators, A and B, produce single-cycle match pulses, and a third output pulses on window checks built from both references. Comparator A always looks at the address bus. Comparator B looks at the address bus in three of the four trigger modes. In the address-plus-data mode it looks at one byte of data, taken from either the read or the write data bus.

Each comparator can require a bus direction. Each can also be told to fire only when the instruction at its address actually executes, not when it is merely fetched. For this the block records a tag per comparator when an opcode fetch hits, and fires on a later execute strobe at the same address. A pipeline flush drops all pending tags. While a background-debug access is running, every match and every tag change is suppressed.

All outputs are registered. A pulse appears in the cycle after the bus cycle or execute strobe that caused it. The interface is plain bus monitoring with no back-pressure: the block only observes, so it has no valid/ready handshake, and the bus is never stalled.

Top module: `dbg_match_unit`

## Requirements
- R1: With `a_opc_en`=0, `match_a` is high in the cycle after a cycle with `bus_valid`=1, `bus_addr`==`cmp_a`, direction qualified (R3) and `bdm_active`=0; otherwise it is low.
- R2: In modes 0 (address pair), 2 (inside) and 3 (outside), with `b_opc_en`=0, `match_b` pulses one cycle after a valid bus cycle whose address equals `cmp_b` and that passes B's direction qualification.
- R3: A direction-enable bit of 0 ignores `bus_rnw`. A direction-enable bit of 1 requires `bus_rnw` (1 = read) to equal the comparator's direction bit (1 = read, 0 = write).
- R4: In mode 1 (address plus data), `match_b` pulses one cycle after a valid bus cycle that meets four conditions: the address equals `cmp_a` with A's direction qualification met; B's direction qualification is met; and the selected data byte equals `cmp_b[7:0]`. The write data bus is selected when `a_dir_en`=1 and `a_dir_rd`=0; otherwise the read data bus is selected.
- R5: With a comparator's tracking bit set, a fetch (`fetch_strobe`=1 together with `bus_valid`=1) that passes that comparator's address and direction check records a tag. The output pulses only one cycle after `exec_strobe`=1 with `exec_addr` equal to the reference while the tag is set, and that pulse clears the tag. A fetch alone never pulses the output. `b_opc_en` has no effect in mode 1.
- R6: In mode 2, `match_range` pulses one cycle after a valid bus cycle with `cmp_a` <= `bus_addr` <= `cmp_b` (unsigned) that passes A's direction qualification. In modes 0 and 1, `match_range` stays low.
- R7: In mode 3, `match_range` pulses one cycle after a valid bus cycle with `bus_addr` < `cmp_a` or `bus_addr` > `cmp_b` (unsigned) that passes A's direction qualification.
- R8: In a cycle with `bdm_active`=1, the cycle after it shows no pulse on any output. In that cycle no tag is recorded and execute strobes leave the tags unchanged.
- R9: `flush`=1 clears both tags. An execute strobe in the same cycle does not fire, and a fetch in the same cycle records no tag.
- R10: A synchronous active-high `rst` clears all outputs and both tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Trigger mode: 0 pair, 1 address+data, 2 inside, 3 outside |
| cmp_a | input | 16 | Reference value of comparator A |
| cmp_b | input | 16 | Reference value of comparator B |
| a_dir_en | input | 1 | A direction qualification enable |
| a_dir_rd | input | 1 | A required direction (1 read) |
| b_dir_en | input | 1 | B direction qualification enable |
| b_dir_rd | input | 1 | B required direction (1 read) |
| a_opc_en | input | 1 | A execute tracking enable |
| b_opc_en | input | 1 | B execute tracking enable |
| bus_valid | input | 1 | A bus cycle occurs this clock |
| bus_addr | input | 16 | Bus address |
| bus_rnw | input | 1 | Bus direction, 1 read |
| bus_rdata | input | 8 | Read data bus |
| bus_wdata | input | 8 | Write data bus |
| fetch_strobe | input | 1 | Current bus cycle is an opcode fetch |
| exec_strobe | input | 1 | An instruction executes this clock |
| exec_addr | input | 16 | Address of the executing instruction |
| flush | input | 1 | Instruction pipeline flush |
| bdm_active | input | 1 | Background-debug access in progress |
| match_a | output | 1 | Comparator A match pulse |
| match_b | output | 1 | Comparator B match pulse |
| match_range | output | 1 | Inside/outside range match pulse |

## Verification
The collision that matters is a pipeline flush landing in the same cycle as an execute strobe, or as a fetch, at a tagged address. The flush must win in both cases: no pulse, and no tag left behind. The bench arms a tag with a directed fetch and then raises flush and a matching execute strobe together. It checks that `match_a` stays low in the following cycle and also after a later lone execute strobe. The random phase mixes flushes, fetches and execute strobes from a small address pool so that these overlaps recur, and a bench reference model judges every cycle.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;
  typedef enum logic [1:0] {
    TRIG_ADDR_PAIR = 2'd0,
    TRIG_ADDR_DATA = 2'd1,
    TRIG_INSIDE    = 2'd2,
    TRIG_OUTSIDE   = 2'd3
  } trig_mode_e;

  // true when the direction check passes (or is disabled)
  function automatic logic dir_ok(input logic en, input logic want_rd, input logic is_rd);
    return !en || (want_rd == is_rd);
  endfunction
endpackage

// File: rtl/dbg_eq_cmp.sv
module dbg_eq_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] ref_val,
  input  logic [W-1:0] bus_val,
  input  logic         dir_en,
  input  logic         dir_rd,
  input  logic         bus_rnw,
  output logic         hit
);
  import dbg_match_pkg::*;
  always_comb hit = (ref_val == bus_val) && dir_ok(dir_en, dir_rd, bus_rnw);
endmodule

// File: rtl/dbg_exec_tag.sv
module dbg_exec_tag #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ref_val,
  input  logic         fetch_hit,
  input  logic         exec_strobe,
  input  logic [W-1:0] exec_addr,
  input  logic         track_en,
  input  logic         flush,
  input  logic         bdm_active,
  output logic         fire
);
  logic tag_q;
  logic arm;

  always_comb begin
    arm  = fetch_hit && !bdm_active && !flush;
    fire = track_en && tag_q && exec_strobe && (exec_addr == ref_val)
           && !flush && !bdm_active;
  end

  always_ff @(posedge clk) begin
    if (rst || flush)  tag_q <= 1'b0;
    else if (arm)      tag_q <= 1'b1;
    else if (fire)     tag_q <= 1'b0;
  end
endmodule

// File: rtl/dbg_range_cmp.sv
module dbg_range_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] addr,
  input  logic         outside,
  output logic         hit
);
  logic in_win;
  always_comb begin
    in_win = (addr >= lo) && (addr <= hi);
    hit    = outside ? !in_win : in_win;
  end
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbg_match_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] cmp_a,
  input  logic [ADDR_W-1:0] cmp_b,
  input  logic              a_dir_en,
  input  logic              a_dir_rd,
  input  logic              b_dir_en,
  input  logic              b_dir_rd,
  input  logic              a_opc_en,
  input  logic              b_opc_en,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rnw,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              fetch_strobe,
  input  logic              exec_strobe,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic              flush,
  input  logic              bdm_active,
  output logic              match_a,
  output logic              match_b,
  output logic              match_range
);
  localparam int NCMP = 2;

  trig_mode_e mode_e;
  assign mode_e = trig_mode_e'(mode);

  logic [ADDR_W-1:0] ref_v  [NCMP];
  logic [NCMP-1:0]   den, drd, trk, addr_hit, fire;

  assign ref_v[0] = cmp_a;
  assign ref_v[1] = cmp_b;
  assign den = {b_dir_en, a_dir_en};
  assign drd = {b_dir_rd, a_dir_rd};
  assign trk = {b_opc_en && (mode_e != TRIG_ADDR_DATA), a_opc_en};

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    dbg_eq_cmp #(.W(ADDR_W)) i_eq (
      .ref_val(ref_v[i]), .bus_val(bus_addr), .dir_en(den[i]),
      .dir_rd(drd[i]), .bus_rnw(bus_rnw), .hit(addr_hit[i])
    );
    dbg_exec_tag #(.W(ADDR_W)) i_tag (
      .clk(clk), .rst(rst), .ref_val(ref_v[i]),
      .fetch_hit(fetch_strobe && bus_valid && addr_hit[i]),
      .exec_strobe(exec_strobe), .exec_addr(exec_addr),
      .track_en(trk[i]), .flush(flush), .bdm_active(bdm_active),
      .fire(fire[i])
    );
  end

  // data-bus selection for the address-plus-data mode
  logic              use_wbus;
  logic [DATA_W-1:0] data_sel;
  logic              data_hit;
  logic              win_hit;
  logic              range_mode;

  always_comb begin
    use_wbus = a_dir_en && !a_dir_rd;
    data_sel = use_wbus ? bus_wdata : bus_rdata;
    data_hit = (data_sel == cmp_b[DATA_W-1:0]) && dir_ok(b_dir_en, b_dir_rd, bus_rnw);
    range_mode = (mode_e == TRIG_INSIDE) || (mode_e == TRIG_OUTSIDE);
  end

  dbg_range_cmp #(.W(ADDR_W)) i_range (
    .lo(cmp_a), .hi(cmp_b), .addr(bus_addr),
    .outside(mode_e == TRIG_OUTSIDE), .hit(win_hit)
  );

  logic a_d, b_d, r_d;
  always_comb begin
    a_d = trk[0] ? fire[0] : (bus_valid && addr_hit[0]);
    if (mode_e == TRIG_ADDR_DATA) b_d = bus_valid && addr_hit[0] && data_hit;
    else                          b_d = trk[1] ? fire[1] : (bus_valid && addr_hit[1]);
    r_d = range_mode && bus_valid && win_hit && dir_ok(a_dir_en, a_dir_rd, bus_rnw);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_a     <= 1'b0;
      match_b     <= 1'b0;
      match_range <= 1'b0;
    end else begin
      match_a     <= a_d && !bdm_active;
      match_b     <= b_d && !bdm_active;
      match_range <= r_d && !bdm_active;
    end
  end
endmodule

// File: rtl/dbg_match_chk.sv
module dbg_match_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       bus_valid,
  input logic       bdm_active,
  input logic       exec_strobe,
  input logic       flush,
  input logic       a_opc_en,
  input logic       match_a,
  input logic       match_b,
  input logic       match_range
);
  // R8
  bdm_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bdm_active) |-> !(match_a || match_b || match_range));
  // R5
  fetch_only_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(a_opc_en) && !$past(exec_strobe)) |-> !match_a);
  // R9
  flush_kill_chk: assert property (@(posedge clk) disable iff (rst)
    $past(flush && a_opc_en) |-> !match_a);
  // R6
  range_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mode[1] == 1'b0) |-> !match_range);
  // R4
  data_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mode == 2'd1 && !bus_valid) |-> !match_b);
  // R1
  a_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!a_opc_en && !bus_valid) |-> !match_a);
  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(match_a || match_b || match_range));
endmodule

bind dbg_match_unit dbg_match_chk i_match_chk (.*);

// File: tb/test_dbg_match_unit.sv
module test_dbg_match_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, a_dir_en, a_dir_rd, b_dir_en, b_dir_rd, a_opc_en, b_opc_en;
  logic [1:0]  mode;
  logic [15:0] cmp_a, cmp_b, bus_addr, exec_addr;
  logic        bus_valid, bus_rnw, fetch_strobe, exec_strobe, flush, bdm_active;
  logic [7:0]  bus_rdata, bus_wdata;
  logic        match_a, match_b, match_range;

  dbg_match_unit i_dbg_match_unit (.*);

  int errors = 0, checks = 0;
  logic [1:0] mtag = 2'b00;
  logic ea, eb, er;

  function automatic logic dok(logic en, logic rd, logic isrd);
    return !en || (rd == isrd);
  endfunction

  task automatic chk(string req, logic got, logic exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  // reference model: compute expectations from current inputs, then clock
  task automatic step(string tag);
    logic ha, hb, qa, xa, xb, fa, fb, btrk, dsel;
    logic [7:0] d;
    string la, lb, lr;
    qa = dok(a_dir_en, a_dir_rd, bus_rnw);
    ha = (bus_addr == cmp_a) && qa;
    hb = (bus_addr == cmp_b) && dok(b_dir_en, b_dir_rd, bus_rnw);
    xa = exec_strobe && exec_addr == cmp_a;
    xb = exec_strobe && exec_addr == cmp_b;
    btrk = b_opc_en && mode != 2'd1;
    fa = a_opc_en && mtag[0] && xa && !flush && !bdm_active;
    fb = btrk && mtag[1] && xb && !flush && !bdm_active;
    dsel = a_dir_en && !a_dir_rd;
    d = dsel ? bus_wdata : bus_rdata;
    ea = a_opc_en ? fa : (bus_valid && ha);
    if (mode == 2'd1)
      eb = bus_valid && ha && dok(b_dir_en, b_dir_rd, bus_rnw) && d == cmp_b[7:0];
    else eb = btrk ? fb : (bus_valid && hb);
    if (mode == 2'd2)      er = bus_valid && qa && bus_addr >= cmp_a && bus_addr <= cmp_b;
    else if (mode == 2'd3) er = bus_valid && qa && (bus_addr < cmp_a || bus_addr > cmp_b);
    else                   er = 1'b0;
    if (bdm_active || rst) begin ea = 0; eb = 0; er = 0; end
    if (rst || flush) mtag = 2'b00;
    else begin
      if (fetch_strobe && bus_valid && ha && !bdm_active) mtag[0] = 1'b1;
      else if (fa) mtag[0] = 1'b0;
      if (fetch_strobe && bus_valid && hb && !bdm_active) mtag[1] = 1'b1;
      else if (fb) mtag[1] = 1'b0;
    end
    la = bdm_active ? "R8" : a_opc_en ? "R5" : a_dir_en ? "R3" : "R1";
    lb = bdm_active ? "R8" : mode == 2'd1 ? "R4" : btrk ? "R5" : "R2";
    lr = bdm_active ? "R8" : mode == 2'd3 ? "R7" : "R6";
    if (tag != "") begin la = tag; lb = tag; lr = tag; end
    @(posedge clk);
    @(negedge clk);
    chk(la, match_a, ea, "match_a");
    chk(lb, match_b, eb, "match_b");
    chk(lr, match_range, er, "match_range");
  endtask

  task automatic idle();
    bus_valid = 0; fetch_strobe = 0; exec_strobe = 0; flush = 0; bdm_active = 0;
    bus_rnw = 1; bus_addr = 16'h0; exec_addr = 16'h0; bus_rdata = 0; bus_wdata = 0;
  endtask

  task automatic cfg(logic [1:0] m, logic [15:0] a, logic [15:0] b);
    mode = m; cmp_a = a; cmp_b = b;
    a_dir_en = 0; a_dir_rd = 1; b_dir_en = 0; b_dir_rd = 1; a_opc_en = 0; b_opc_en = 0;
  endtask

  function automatic logic [15:0] pick_addr();
    case ($urandom_range(0, 5))
      0: return cmp_a;
      1: return cmp_b;
      2: return cmp_a - 16'd1;
      3: return cmp_b + 16'd1;
      4: return cmp_a + 16'($urandom_range(0, 3));
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    idle();
    cfg(2'd2, 16'h1000, 16'h2000);
    rst = 1;
    bus_valid = 1; bus_addr = 16'h1000;
    @(negedge clk);
    step("R10");
    step("R10");
    rst = 0;
    idle();
    step("R10");

    // R5: fetch alone must not fire; execute afterwards fires once
    cfg(2'd0, 16'h4321, 16'h5555);
    a_opc_en = 1;
    bus_valid = 1; fetch_strobe = 1; bus_addr = 16'h4321;
    step("R5");
    idle();
    step("R5");
    chk("R5", match_a, 1'b0, "fetch-only match_a");
    exec_strobe = 1; exec_addr = 16'h4321;
    step("R5");
    chk("R5", match_a, 1'b1, "exec match_a");
    step("R5");
    chk("R5", match_a, 1'b0, "tag consumed match_a");
    idle();

    // R9: flush together with a matching execute strobe
    bus_valid = 1; fetch_strobe = 1; bus_addr = 16'h4321;
    step("R9");
    idle();
    flush = 1; exec_strobe = 1; exec_addr = 16'h4321;
    step("R9");
    chk("R9", match_a, 1'b0, "flush+exec match_a");
    flush = 0;
    step("R9");
    chk("R9", match_a, 1'b0, "exec after flush match_a");
    idle();

    // R4: write data bus selected when A qualifies on writes
    cfg(2'd1, 16'h0080, 16'h00A5);
    a_dir_en = 1; a_dir_rd = 0;
    bus_valid = 1; bus_rnw = 0; bus_addr = 16'h0080; bus_wdata = 8'hA5; bus_rdata = 8'h3C;
    step("R4");
    chk("R4", match_b, 1'b1, "write-bus match_b");
    bus_wdata = 8'h3C; bus_rdata = 8'hA5;
    step("R4");
    chk("R4", match_b, 1'b0, "read-bus ignored match_b");
    idle();

    // R6 / R7 window edges
    cfg(2'd2, 16'h0100, 16'h01FF);
    bus_valid = 1; bus_addr = 16'h01FF;
    step("R6");
    chk("R6", match_range, 1'b1, "inside upper edge");
    bus_addr = 16'h0200;
    step("R6");
    chk("R6", match_range, 1'b0, "inside past edge");
    mode = 2'd3; bus_addr = 16'h00FF;
    step("R7");
    chk("R7", match_range, 1'b1, "outside below");
    bus_addr = 16'h0100;
    step("R7");
    chk("R7", match_range, 1'b0, "outside at lower edge");

    // R8: debug access silences a hit
    cfg(2'd0, 16'h0300, 16'h0300);
    bus_valid = 1; bus_addr = 16'h0300; bdm_active = 1;
    step("R8");
    chk("R8", match_a, 1'b0, "bdm match_a");
    idle();

    // constrained random
    for (int blk = 0; blk < 40; blk++) begin
      cfg(2'($urandom_range(0, 3)), 16'($urandom), 16'h0);
      cmp_b = cmp_a + 16'($urandom_range(0, 40)) - 16'd4;
      a_dir_en = 1'($urandom); a_dir_rd = 1'($urandom);
      b_dir_en = 1'($urandom); b_dir_rd = 1'($urandom);
      a_opc_en = 1'($urandom); b_opc_en = 1'($urandom);
      for (int c = 0; c < 100; c++) begin
        bus_valid    = ($urandom_range(0, 3) != 0);
        bus_addr     = pick_addr();
        bus_rnw      = 1'($urandom);
        bus_rdata    = ($urandom_range(0, 2) == 0) ? cmp_b[7:0] : 8'($urandom);
        bus_wdata    = ($urandom_range(0, 2) == 0) ? cmp_b[7:0] : 8'($urandom);
        fetch_strobe = ($urandom_range(0, 2) == 0);
        exec_strobe  = ($urandom_range(0, 2) == 0);
        exec_addr    = pick_addr();
        flush        = ($urandom_range(0, 15) == 0);
        bdm_active   = ($urandom_range(0, 15) == 0);
        step("");
      end
      idle();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule